// File: doc/BRIEF.md
# Dual-Edge Eight-Lane 1:4 Deserializer

This block receives one source-synchronous group of eight serial data lanes that travel with a single forwarded clock. Each lane is sampled on both edges of that clock, so every clock period yields two bits per lane. At the nominal rates each lane carries 800 Mbps and the forwarded clock runs at 400 MHz. The block widens each lane by four into a nibble and presents the eight nibbles as one 32-bit word with a write strobe. The word and strobe are paired with a clock at half the forwarded frequency (200 MHz nominal) that the block generates itself. That clock is meant to serve as the write clock of an adjacent FIFO.

Twenty copies placed next to each other form a 640-bit bus. A word-boundary slip control lets a later alignment routine move the nibble boundary one bit at a time on all eight lanes together. Line receivers, delay tuning, training and the FIFO itself sit outside this block.

Top module: `ddr_group_deser`

## Requirements
- R1: On each lane, the bit sampled at a rising edge of `fwdClk` comes before the bit sampled at the falling edge that follows it. Rising edges of `fwdClk` are numbered n. The rising-edge sample at edge n is stream bit 2n, and the falling-edge sample after it is stream bit 2n+1.
- R2: Lane l occupies `wordOut[4l+3:4l]`. Within a nibble, bit 3 is the oldest stream bit and bit 0 the newest.
- R3: `divClk` is 0 during reset. It goes to 1 at the first rising edge of `fwdClk` after reset is released, and it inverts at every rising edge after that.
- R4: `wordOut` and `wrEn` change only at the rising edges of `fwdClk` at which `divClk` falls. These are the load edges, and both outputs hold their values for the full `divClk` period in between.
- R5: Let the slip count be d. When a load edge n updates the word, lane l nibble bit b equals stream bit 2n-3-d-b of lane l.
- R6: Let edge R be the last rising edge with reset high. `wrEn` is 0 at the load edges R+2 and R+4. From edge R+6 on, `wrEn` is 1 and the word is updated at every load edge.
- R7: After any rising edge of `fwdClk` with `rst` high, `wrEn` is 0, `divClk` is 0, `wordOut` is zero and the slip count is 0.
- R8: When `bitSlip` is high at a rising edge of `fwdClk` outside reset, the slip count d increases by one, modulo 4. The new count applies to every lane from the next load edge on.
- R9: After four slips the lanes return to the word boundary they had with d = 0.
- R10: A `bitSlip` pulse while `rst` is high has no effect, and the slip count is 0 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fwdClk | input | 1 | Forwarded source clock, sampled on both edges |
| rst | input | 1 | Synchronous active-high reset, sampled on rising `fwdClk` |
| laneIn | input | 8 | Serial data, one bit per lane |
| bitSlip | input | 1 | Moves the nibble boundary by one bit on all lanes |
| divClk | output | 1 | Half-rate clock for the downstream FIFO write side |
| wordOut | output | 32 | Eight 4-bit lane words, lane 0 in the low nibble |
| wrEn | output | 1 | Word valid, held for whole `divClk` periods |

## Verification
The assertions check every cycle that `divClk` alternates, that `wordOut` and `wrEn` move only at a falling `divClk`, that the outputs clear after reset, and that `wrEn` comes up at exactly the third load edge after release and then stays high. Only the bench's scenarios can show that the bits land in the right nibble, in the right order, and at the right stream position. The same goes for the effect of each slip count, the wrap after four slips, and a slip pulse being ignored during reset. The bench drives several data patterns for these: alternating rise/fall values, a walking lane marker and pseudo-random streams.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

  localparam int DEF_LANES = 8;
  localparam int DEF_RATIO = 4;

  // Strobes from the control side to the datapath, valid at one fwdClk edge.
  typedef struct packed {
    logic loadWord;   // this edge is a load edge (divClk falls)
    logic wordValid;  // history holds enough post-reset bits for any slip
  } ctlStrobes_t;

endpackage

// File: rtl/ddr_deser_ctl.sv
module ddr_deser_ctl
  import ddr_deser_pkg::*;
#(
  parameter int RATIO = DEF_RATIO
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bitSlip,
  output ctlStrobes_t               strobes,
  output logic [$clog2(RATIO)-1:0]  slipSel,
  output logic                      divClk
);

  localparam int CYC       = RATIO / 2;             // fwdClk cycles per word
  localparam int PHASE_W   = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int FILL_NEED = RATIO;                 // pairs covering widest window
  localparam int FILL_W    = $clog2(FILL_NEED + 1);
  localparam int SLIP_W    = $clog2(RATIO);

  logic [PHASE_W-1:0] phase, nextPhase;
  logic [FILL_W-1:0]  fill;
  logic               atLoad;

  always_comb begin
    atLoad    = (phase == PHASE_W'(CYC - 1));
    nextPhase = atLoad ? '0 : phase + PHASE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      fill    <= '0;
      slipSel <= '0;
      divClk  <= 1'b0;
    end else begin
      phase  <= nextPhase;
      divClk <= (nextPhase >= PHASE_W'(CYC / 2));
      if (fill != FILL_W'(FILL_NEED))
        fill <= fill + FILL_W'(1);
      if (bitSlip)
        slipSel <= slipSel + SLIP_W'(1);
    end
  end

  always_comb begin
    strobes.loadWord  = atLoad & ~rst;
    strobes.wordValid = (fill == FILL_W'(FILL_NEED));
  end

endmodule

// File: rtl/ddr_deser_dp.sv
module ddr_deser_dp
  import ddr_deser_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int RATIO = DEF_RATIO
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          laneIn,
  input  ctlStrobes_t               strobes,
  input  logic [$clog2(RATIO)-1:0]  slipSel,
  output logic [LANES*RATIO-1:0]    wordOut,
  output logic                      wrEn
);

  localparam int HIST_LEN = 2 * RATIO - 1;  // word plus the largest slip
  localparam int WORD_W   = LANES * RATIO;

  logic [WORD_W-1:0] assembled;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic                riseQ, fallQ;
    logic [HIST_LEN-1:0] hist;  // bit 0 newest

    always_ff @(posedge clk) riseQ <= laneIn[l];
    always_ff @(negedge clk) fallQ <= laneIn[l];

    // The rising sample is the earlier bit of each pair.
    always_ff @(posedge clk) hist <= {hist[HIST_LEN-3:0], riseQ, fallQ};

    assign assembled[l*RATIO +: RATIO] = hist[slipSel +: RATIO];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordOut <= '0;
      wrEn    <= 1'b0;
    end else if (strobes.loadWord) begin
      wrEn <= strobes.wordValid;
      if (strobes.wordValid)
        wordOut <= assembled;
    end
  end

endmodule

// File: rtl/ddr_group_deser.sv
module ddr_group_deser
  import ddr_deser_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int RATIO = DEF_RATIO
) (
  input  logic                   fwdClk,
  input  logic                   rst,
  input  logic [LANES-1:0]       laneIn,
  input  logic                   bitSlip,
  output logic                   divClk,
  output logic [LANES*RATIO-1:0] wordOut,
  output logic                   wrEn
);

  localparam int SLIP_W = $clog2(RATIO);

  ctlStrobes_t       strobes;
  logic [SLIP_W-1:0] slipSel;

  ddr_deser_ctl #(.RATIO(RATIO)) u_ctl (
    .clk     (fwdClk),
    .rst     (rst),
    .bitSlip (bitSlip),
    .strobes (strobes),
    .slipSel (slipSel),
    .divClk  (divClk)
  );

  ddr_deser_dp #(.LANES(LANES), .RATIO(RATIO)) u_dp (
    .clk     (fwdClk),
    .rst     (rst),
    .laneIn  (laneIn),
    .strobes (strobes),
    .slipSel (slipSel),
    .wordOut (wordOut),
    .wrEn    (wrEn)
  );

endmodule

// File: rtl/ddr_deser_chk.sv
module ddr_deser_chk #(
  parameter int LANES = 8,
  parameter int RATIO = 4
) (
  input logic                   fwdClk,
  input logic                   rst,
  input logic                   divClk,
  input logic [LANES*RATIO-1:0] wordOut,
  input logic                   wrEn
);

  localparam int CYC        = RATIO / 2;
  localparam int FIRST_LOAD = (RATIO + 1 + CYC - 1) / CYC;
  localparam int CNT_W      = $clog2(FIRST_LOAD + 1);

  // Load edges seen since reset, saturating at the one that raises wrEn.
  logic [CNT_W-1:0] loadCnt;
  always_ff @(posedge fwdClk) begin
    if (rst)
      loadCnt <= '0;
    else if (divClk && loadCnt != CNT_W'(FIRST_LOAD))
      loadCnt <= loadCnt + CNT_W'(1);
  end

  p_div_toggle_r3: assert property (@(posedge fwdClk) disable iff (rst)
    !$past(rst) |-> (divClk != $past(divClk)));

  p_word_hold_r4: assert property (@(posedge fwdClk) disable iff (rst)
    !$stable(wordOut) |-> $fell(divClk));

  p_en_hold_r4: assert property (@(posedge fwdClk) disable iff (rst)
    !$stable(wrEn) |-> $fell(divClk));

  p_enable_start_r6: assert property (@(posedge fwdClk) disable iff (rst)
    1'b1 |-> (wrEn == (loadCnt == CNT_W'(FIRST_LOAD))));

  p_reset_out_r7: assert property (@(posedge fwdClk) disable iff (rst)
    $past(rst) |-> (!wrEn && !divClk && wordOut == '0));

endmodule

bind ddr_group_deser ddr_deser_chk #(.LANES(LANES), .RATIO(RATIO)) u_chk (
  .fwdClk  (fwdClk),
  .rst     (rst),
  .divClk  (divClk),
  .wordOut (wordOut),
  .wrEn    (wrEn)
);

// File: tb/ddr_group_deser_bench.sv
module ddr_group_deser_bench;

  localparam int CLK_PERIOD = 8;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int LANES      = 8;
  localparam int RATIO      = 4;

  logic              fwdClk = 1'b0;
  logic              rst = 1'b1;
  logic              bitSlip = 1'b0;
  logic [LANES-1:0]  laneIn;
  logic              divClk;
  logic [31:0]       wordOut;
  logic              wrEn;

  int cyc = 0;
  int relEdge = 0;
  int slipD = 0;
  int pat = 0;
  int nChecks = 0;
  int nFails = 0;
  logic [31:0] lastWord;
  logic        lastEn;

  ddr_group_deser u_ddr_group_deser (
    .fwdClk (fwdClk), .rst (rst), .laneIn (laneIn), .bitSlip (bitSlip),
    .divClk (divClk), .wordOut (wordOut), .wrEn (wrEn)
  );

  always #(CLK_PERIOD / 2) fwdClk = ~fwdClk;
  always @(posedge fwdClk) cyc <= cyc + 1;

  // Stream bit j of lane l under the current pattern.
  function automatic logic sbit(int l, int j);
    int h;
    if (j < 0) return 1'b0;
    case (pat)
      1: return j[0];                       // rise 0, fall 1
      2: return ((j % LANES) == l);         // walking lane marker
      default: begin
        h = j * 1103 + l * 12345 + (j >> 3) * 977;
        h = h ^ (h >> 5);
        return h[4];
      end
    endcase
  endfunction

  function automatic logic [LANES-1:0] lanesAt(int j);
    logic [LANES-1:0] v;
    for (int l = 0; l < LANES; l++) v[l] = sbit(l, j);
    return v;
  endfunction

  function automatic logic [31:0] expWord(int n, int d);
    logic [31:0] w;
    for (int l = 0; l < LANES; l++)
      for (int b = 0; b < RATIO; b++)
        w[l*RATIO + b] = sbit(l, 2*n - 3 - d - b);
    return w;
  endfunction

  // Rise bit for edge n is driven before it, fall bit just after it.
  initial laneIn = lanesAt(2);
  always @(posedge fwdClk) begin #(QTR); laneIn = lanesAt(2*cyc + 1); end
  always @(negedge fwdClk) begin #(QTR); laneIn = lanesAt(2*(cyc + 1)); end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", req, act, exp, cyc);
    end
  endtask

  // Reset sequence; optional slip pulse while reset is high (R10).
  task automatic doReset(bit slipInReset);
    @(posedge fwdClk); #(QTR);
    rst = 1'b1;
    bitSlip = slipInReset;
    @(posedge fwdClk); #(QTR);
    bitSlip = 1'b0;
    @(posedge fwdClk); #(QTR);
    chk("R7 wrEn in reset", 32'(wrEn), 32'd0);
    chk("R7 divClk in reset", 32'(divClk), 32'd0);
    chk("R7 word in reset", wordOut, 32'd0);
    @(posedge fwdClk); #(QTR);
    relEdge = cyc;
    rst = 1'b0;
    slipD = 0;
    lastWord = 32'd0;
    lastEn = 1'b0;
  endtask

  // Observe nEdges edges; request nSlips slips at load edges once enabled.
  task automatic runEdges(int nEdges, int nSlips, string tag);
    int k;
    int slipsLeft = nSlips;
    for (int i = 0; i < nEdges; i++) begin
      @(posedge fwdClk); #(QTR);
      bitSlip = 1'b0;
      k = cyc - relEdge;
      chk("R3 divClk phase", 32'(divClk), 32'(k % 2));
      if (k % 2 == 0) begin
        chk("R6 wrEn at load edge", 32'(wrEn), 32'(k >= 6));
        if (k >= 6) begin
          chk($sformatf("R5 %s word d=%0d", tag, slipD), wordOut, expWord(cyc, slipD));
          if (nSlips > 0 && slipsLeft == 0 && slipD == 0)
            chk("R9 wrapped alignment", wordOut, expWord(cyc, 0));
          if (slipsLeft > 0 && k >= 8) begin
            bitSlip = 1'b1;
            slipD = (slipD + 1) % RATIO;
            slipsLeft--;
          end
        end else begin
          chk("R6 word held before enable", wordOut, 32'd0);
        end
      end else begin
        chk("R4 word held", wordOut, lastWord);
        chk("R4 wrEn held", 32'(wrEn), 32'(lastEn));
      end
      lastWord = wordOut;
      lastEn = wrEn;
    end
  endtask

  task automatic t_reset_state;
    pat = 0;
    doReset(1'b0);
    runEdges(8, 0, "R6 startup");
  endtask

  task automatic t_random_stream;
    pat = 0;
    doReset(1'b0);
    runEdges(60, 0, "random");
  endtask

  task automatic t_edge_order;
    pat = 1;
    doReset(1'b0);
    runEdges(10, 0, "alternating");
    @(posedge fwdClk); #(QTR);
    if (divClk == 1'b0) begin @(posedge fwdClk); #(QTR); end
    chk("R1 rise bit older than fall bit", wordOut, {LANES{4'b0101}});
  endtask

  task automatic t_lane_order;
    pat = 2;
    doReset(1'b0);
    runEdges(24, 0, "R2 walking");
  endtask

  task automatic t_slip;
    pat = 0;
    doReset(1'b0);
    runEdges(40, 4, "R8 slip");
    chk("R9 slip count wrapped", 32'(slipD), 32'd0);
  endtask

  task automatic t_slip_in_reset;
    pat = 0;
    doReset(1'b1);
    runEdges(16, 0, "R10 slip ignored in reset");
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_random_stream();
    t_edge_order();
    t_lane_order();
    t_slip();
    t_slip_in_reset();
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule